// File: doc/BRIEF.md
# Two-Channel Sequential Break Trigger

This block decides when a debug break should be raised from two comparator channels. Each channel receives a one-cycle hit pulse from an external address or data comparator, plus three control bits: a break enable, a sequence enable and a partner index. Every qualifying hit sets a sticky per-channel hit flag. Software clears these flags through a write-one-to-clear port.

A channel can raise a break on its own. It can also act as the second stage of an ordered pair. In that case it only qualifies once its partner's flag was already set in an earlier cycle. The order can be channel 0 then channel 1, or channel 1 then channel 0. The first stage of a pair is programmed with both its enables low, so it only arms its flag. Channel 1 can also demand that its hit occur a programmed number of times before it counts, using a reloadable down-counter.

A qualified break is held pending and released as a one-cycle request at the next instruction boundary that is not a delay slot. A break that lands on a delayed branch or its slot is therefore taken at the first instruction of the branch target.

Top module: `seq_break_trigger`

## Requirements
- R1: After reset, `flags`, `brk_req`, `brk_src` and `cnt_value` are all zero.
- R2: A qualifying hit on channel i sets `flags[i]` at the next clock edge, whatever the channel's enable bits are. The flag stays set until it is cleared.
- R3: A cycle with `flag_clr_we`=1 clears each `flags[i]` whose `flag_clr_data[i]` is 1 and leaves the other flags unchanged. A qualifying hit on the same channel in the same cycle wins, and the flag stays 1.
- R4: A channel with `brk_en[i]`=1 and `seq_en[i]`=0 qualifies a break on each qualifying hit. The request appears on `brk_req` with bit i set in `brk_src`.
- R5: A channel with `brk_en[i]`=0 never causes a break request.
- R6: A channel with `seq_en[i]`=1 qualifies only if the flag of the channel named by its partner index (bits `partner_sel[i]` for two channels) was already set before the cycle of its hit. A partner hit in the same cycle does not count.
- R7: Ordered pairs work in both directions: channel 0 then channel 1, and channel 1 then channel 0.
- R8: A first-stage flag stays armed across any number of idle cycles. Once software clears it, a later second-stage hit does not break.
- R9: When `cnt_en`=1, a channel 1 hit qualifies only while `cnt_value` is 0 or 1. Each channel 1 hit decrements `cnt_value` while it is above 1, and the value holds at 1 after that. `cnt_load` writes `cnt_load_val` and wins over a simultaneous hit. When `cnt_en`=0, every channel 1 hit qualifies and the count does not change.
- R10: A pending break is released only by a cycle with `insn_bnd`=1 and `bnd_is_slot`=0 that comes after the qualifying cycle. Slot boundaries and a boundary in the qualifying cycle itself do not release it.
- R11: `brk_req` goes high for one cycle, in the cycle after the releasing boundary, and `brk_src` then shows the pending channels. After release nothing is pending, except a break that qualified in the releasing cycle; that break waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_hit | input | NUM_CH | Per-channel comparator hit pulse |
| brk_en | input | NUM_CH | Per-channel break enable |
| seq_en | input | NUM_CH | Per-channel sequence (second stage) enable |
| partner_sel | input | NUM_CH*IDX_W | Partner channel index, IDX_W bits per channel |
| cnt_en | input | 1 | Apply the hit-count condition to the counted channel |
| cnt_load | input | 1 | Load the hit counter |
| cnt_load_val | input | CNT_W | Counter load value |
| flag_clr_we | input | 1 | Write strobe of the flag clear port |
| flag_clr_data | input | NUM_CH | Write-one-to-clear mask for the flags |
| insn_bnd | input | 1 | An instruction boundary occurs this cycle |
| bnd_is_slot | input | 1 | The boundary is a delayed-branch slot |
| flags | output | NUM_CH | Sticky hit flags |
| cnt_value | output | CNT_W | Current hit counter value |
| brk_req | output | 1 | One-cycle break request |
| brk_src | output | NUM_CH | Channels behind the current request |

## Verification
Two collisions matter here. A software flag clear can fall in the same cycle as a new hit on that channel. The bench drives both together and expects the flag to stay set. A break can qualify in the same cycle that an earlier pending break is released. The bench drives a hit together with a releasing boundary and expects two separate request pulses, the second on the following boundary. The bench also drives both channels of a pair in one cycle and expects no break, because the partner flag was not yet set.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  // Sticky flag update: a new hit outranks a software clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // Counter state classes for the counted channel.
  typedef enum logic [1:0] {
    CNT_IDLE  = 2'd0,
    CNT_LOAD  = 2'd1,
    CNT_DEC   = 2'd2,
    CNT_FLOOR = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/sbt_hit_counter.sv
module sbt_hit_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value,
  output logic             hit_qual
);
  import sbt_pkg::*;

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] value_q;
  logic             at_floor;
  cnt_op_e          op;

  assign at_floor = (value_q <= ONE);

  always_comb begin
    if (load)                    op = CNT_LOAD;
    else if (hit && cnt_en)      op = at_floor ? CNT_FLOOR : CNT_DEC;
    else                         op = CNT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else begin
      unique case (op)
        CNT_LOAD:  value_q <= load_val;
        CNT_DEC:   value_q <= value_q - ONE;
        default:   value_q <= value_q;
      endcase
    end
  end

  // The hit counts when the count condition is off, or once the floor is reached.
  assign hit_qual = hit && (!cnt_en || at_floor);
  assign value    = value_q;

endmodule

// File: rtl/sbt_channel.sv
module sbt_channel #(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_eff,
  input  logic              brk_en,
  input  logic              seq_en,
  input  logic [IDX_W-1:0]  partner,
  input  logic [NUM_CH-1:0] flags_all,
  input  logic              clr,
  output logic              flag,
  output logic              qualify
);
  import sbt_pkg::*;

  logic flag_q;
  logic partner_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, hit_eff, clr);
  end

  // Only flags registered in an earlier cycle arm the second stage.
  always_comb begin
    partner_armed = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (partner == IDX_W'(k)) partner_armed = flags_all[k];
    end
  end

  assign qualify = hit_eff && brk_en && (!seq_en || partner_armed);
  assign flag    = flag_q;

endmodule

// File: rtl/sbt_break_sched.sv
module sbt_break_sched #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] qualify,
  input  logic              insn_bnd,
  input  logic              bnd_is_slot,
  output logic              brk_req,
  output logic [NUM_CH-1:0] brk_src
);
  logic [NUM_CH-1:0] pend_q;
  logic              release_now;
  logic              req_q;
  logic [NUM_CH-1:0] src_q;

  assign release_now = (|pend_q) && insn_bnd && !bnd_is_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      req_q  <= 1'b0;
      src_q  <= '0;
    end else begin
      pend_q <= (release_now ? '0 : pend_q) | qualify;
      req_q  <= release_now;
      src_q  <= release_now ? pend_q : '0;
    end
  end

  assign brk_req = req_q;
  assign brk_src = src_q;

endmodule

// File: rtl/seq_break_trigger.sv
module seq_break_trigger #(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int CNT_W  = 12,
  parameter int CNT_CH = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       ch_hit,
  input  logic [NUM_CH-1:0]       brk_en,
  input  logic [NUM_CH-1:0]       seq_en,
  input  logic [NUM_CH*IDX_W-1:0] partner_sel,
  input  logic                    cnt_en,
  input  logic                    cnt_load,
  input  logic [CNT_W-1:0]        cnt_load_val,
  input  logic                    flag_clr_we,
  input  logic [NUM_CH-1:0]       flag_clr_data,
  input  logic                    insn_bnd,
  input  logic                    bnd_is_slot,
  output logic [NUM_CH-1:0]       flags,
  output logic [CNT_W-1:0]        cnt_value,
  output logic                    brk_req,
  output logic [NUM_CH-1:0]       brk_src
);
  logic [NUM_CH-1:0] hit_eff;
  logic [NUM_CH-1:0] qualify;
  logic [NUM_CH-1:0] flag_vec;
  logic [NUM_CH-1:0] clr_vec;

  assign clr_vec = flag_clr_we ? flag_clr_data : '0;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    if (ch == CNT_CH) begin : g_counted
      sbt_hit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (ch_hit[ch]),
        .cnt_en   (cnt_en),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .value    (cnt_value),
        .hit_qual (hit_eff[ch])
      );
    end else begin : g_plain
      assign hit_eff[ch] = ch_hit[ch];
    end

    sbt_channel #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_eff   (hit_eff[ch]),
      .brk_en    (brk_en[ch]),
      .seq_en    (seq_en[ch]),
      .partner   (partner_sel[ch*IDX_W +: IDX_W]),
      .flags_all (flag_vec),
      .clr       (clr_vec[ch]),
      .flag      (flag_vec[ch]),
      .qualify   (qualify[ch])
    );
  end

  if (CNT_CH >= NUM_CH) begin : g_no_counter
    assign cnt_value = '0;
  end

  sbt_break_sched #(.NUM_CH(NUM_CH)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .qualify     (qualify),
    .insn_bnd    (insn_bnd),
    .bnd_is_slot (bnd_is_slot),
    .brk_req     (brk_req),
    .brk_src     (brk_src)
  );

  assign flags = flag_vec;

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_hit,
  input logic              flag_clr_we,
  input logic [NUM_CH-1:0] flag_clr_data,
  input logic              cnt_load,
  input logic              insn_bnd,
  input logic              bnd_is_slot,
  input logic [NUM_CH-1:0] flags,
  input logic [CNT_W-1:0]  cnt_value,
  input logic              brk_req,
  input logic [NUM_CH-1:0] brk_src
);
  // Channel 0 carries no count condition, so its raw hit always qualifies.
  a_r2_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit[0] |=> flags[0]);

  a_r3_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_we && flag_clr_data[0] && !ch_hit[0]) |=> !flags[0]);

  a_r9_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> (cnt_value <= $past(cnt_value)));

  a_r10_release_on_plain_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(insn_bnd && !bnd_is_slot));

  a_r11_source_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_src != '0));

  a_r11_quiet_source: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> (brk_src == '0));
endmodule

bind seq_break_trigger sbt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sbt_chk (.*);

// File: tb/seq_break_trigger_test.sv
`timescale 1ns/100ps
module seq_break_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ch_hit, brk_en, seq_en, partner_sel, flag_clr_data;
  logic        cnt_en, cnt_load, flag_clr_we, insn_bnd, bnd_is_slot;
  logic [11:0] cnt_load_val;
  logic [1:0]  flags, brk_src;
  logic [11:0] cnt_value;
  logic        brk_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_break_trigger uut (
    .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .brk_en(brk_en), .seq_en(seq_en),
    .partner_sel(partner_sel), .cnt_en(cnt_en), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .flag_clr_we(flag_clr_we),
    .flag_clr_data(flag_clr_data), .insn_bnd(insn_bnd), .bnd_is_slot(bnd_is_slot),
    .flags(flags), .cnt_value(cnt_value), .brk_req(brk_req), .brk_src(brk_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Clear pulses; configuration bits persist.
  task automatic quiet();
    ch_hit = '0; cnt_load = 1'b0; flag_clr_we = 1'b0; flag_clr_data = '0;
    insn_bnd = 1'b0; bnd_is_slot = 1'b0;
  endtask

  // Inputs are driven after a falling edge; one rising edge; sample at the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic cfg(input logic [1:0] be, input logic [1:0] se, input logic [1:0] ps);
    brk_en = be; seq_en = se; partner_sel = ps;
  endtask

  task automatic clear_all();
    flag_clr_we = 1'b1; flag_clr_data = 2'b11;
    step();
  endtask

  task automatic boundary();
    insn_bnd = 1'b1; bnd_is_slot = 1'b0;
    step();
  endtask

  task automatic t_reset();
    check("R1 flags", 32'(flags), 0);
    check("R1 brk_req", 32'(brk_req), 0);
    check("R1 brk_src", 32'(brk_src), 0);
    check("R1 cnt_value", 32'(cnt_value), 0);
  endtask

  task automatic t_single();
    cfg(2'b01, 2'b00, 2'b10);
    ch_hit = 2'b01; insn_bnd = 1'b1;            // same-cycle boundary must not release
    step();
    check("R2 flag0 set", 32'(flags), 32'h1);
    check("R10 same-cycle boundary", 32'(brk_req), 0);
    insn_bnd = 1'b1; bnd_is_slot = 1'b1;        // delay slot boundary
    step();
    check("R10 slot boundary held", 32'(brk_req), 0);
    boundary();
    check("R4 break issued", 32'(brk_req), 1);
    check("R4 source ch0", 32'(brk_src), 32'h1);
    step();
    check("R11 single pulse", 32'(brk_req), 0);
    boundary();
    check("R11 nothing pending", 32'(brk_req), 0);
    check("R2 flag sticky", 32'(flags), 32'h1);
    clear_all();
  endtask

  task automatic t_no_enable();
    cfg(2'b00, 2'b00, 2'b10);
    ch_hit = 2'b10;
    step();
    check("R2 flag1 set without enable", 32'(flags), 32'h2);
    boundary();
    check("R5 disabled channel", 32'(brk_req), 0);
    boundary();
    check("R5 disabled channel later", 32'(brk_req), 0);
  endtask

  task automatic t_clear();
    ch_hit = 2'b01;
    step();
    check("R3 both flags up", 32'(flags), 32'h3);
    flag_clr_we = 1'b1; flag_clr_data = 2'b01;
    step();
    check("R3 masked clear", 32'(flags), 32'h2);
    flag_clr_we = 1'b1; flag_clr_data = 2'b10; ch_hit = 2'b10;
    step();
    check("R3 hit beats clear", 32'(flags), 32'h2);
    flag_clr_we = 1'b0; flag_clr_data = 2'b10;
    step();
    check("R3 no strobe no clear", 32'(flags), 32'h2);
    clear_all();
    check("R3 all cleared", 32'(flags), 0);
  endtask

  task automatic t_seq01();
    cfg(2'b10, 2'b10, 2'b00);                   // ch1 second stage, partner = ch0
    ch_hit = 2'b10;
    step();
    boundary();
    check("R6 second stage alone", 32'(brk_req), 0);
    clear_all();
    ch_hit = 2'b11;                             // both in one cycle
    step();
    boundary();
    check("R6 same-cycle pair", 32'(brk_req), 0);
    clear_all();
    ch_hit = 2'b01;
    step();
    for (int i = 0; i < 6; i++) step();
    check("R8 armed flag held", 32'(flags), 32'h1);
    ch_hit = 2'b10;
    step();
    boundary();
    check("R7 order 0 then 1", 32'(brk_req), 1);
    check("R7 source ch1", 32'(brk_src), 32'h2);
    clear_all();
    ch_hit = 2'b01;
    step();
    flag_clr_we = 1'b1; flag_clr_data = 2'b01;
    step();
    ch_hit = 2'b10;
    step();
    boundary();
    check("R8 released pair", 32'(brk_req), 0);
    clear_all();
  endtask

  task automatic t_seq10();
    cfg(2'b01, 2'b01, 2'b01);                   // ch0 second stage, partner = ch1
    ch_hit = 2'b10;
    step();
    ch_hit = 2'b01;
    step();
    boundary();
    check("R7 order 1 then 0", 32'(brk_req), 1);
    check("R7 source ch0", 32'(brk_src), 32'h1);
    clear_all();
  endtask

  task automatic t_count();
    cfg(2'b10, 2'b00, 2'b10);
    cnt_en = 1'b1; cnt_load = 1'b1; cnt_load_val = 12'd3;
    step();
    check("R9 loaded", 32'(cnt_value), 3);
    ch_hit = 2'b10;
    step();
    check("R9 first hit counts down", 32'(cnt_value), 2);
    check("R9 no flag yet", 32'(flags), 0);
    ch_hit = 2'b10;
    step();
    check("R9 second hit", 32'(cnt_value), 1);
    boundary();
    check("R9 no break before count", 32'(brk_req), 0);
    ch_hit = 2'b10;
    step();
    check("R9 third hit flags", 32'(flags), 32'h2);
    check("R9 holds at one", 32'(cnt_value), 1);
    boundary();
    check("R9 counted break", 32'(brk_req), 1);
    ch_hit = 2'b10; cnt_load = 1'b1; cnt_load_val = 12'd5;
    step();
    check("R9 load beats hit", 32'(cnt_value), 5);
    cnt_en = 1'b0; ch_hit = 2'b10;
    step();
    check("R9 count off unchanged", 32'(cnt_value), 5);
    clear_all();
  endtask

  task automatic t_refire();
    cfg(2'b01, 2'b00, 2'b10);
    ch_hit = 2'b01;
    step();
    ch_hit = 2'b01; insn_bnd = 1'b1;
    step();
    check("R11 first pulse", 32'(brk_req), 1);
    boundary();
    check("R11 refire pulse", 32'(brk_req), 1);
    boundary();
    check("R11 drained", 32'(brk_req), 0);
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg(2'b00, 2'b00, 2'b10);
    cnt_en = 1'b0; cnt_load_val = '0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_no_enable();
    t_clear();
    t_seq01();
    t_seq10();
    t_count();
    t_refire();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule